// File: doc/BRIEF.md
# End-of-Conversion Triggered SPI Frame Reader

This block is an SPI master that sits between a multichannel neural-recording converter chip and an on-chip sample buffer. The slave raises an end-of-conversion line each time a new pair of channel samples is ready. The slave has sixteen inputs at 10-bit resolution, so eight frames cover every channel once. After a start pulse, the master first programs the slave's operating mode by writing a fixed list of configuration words. Each word goes out in its own chip-select frame. From then on, every rising edge of the end-of-conversion line starts exactly one 22-bit read. The read frame is handed downstream for one cycle, along with its decoded tag and its two channel samples.

The link runs in SPI mode 0. SCLK idles low. MOSI moves only while SCLK is low. MISO is captured on the rising SCLK edge, most significant bit first, and chip-select stays low for the whole frame. The SCLK period is set by a divisor register. An end-of-conversion edge that arrives during a transfer is held as a pending request and is served as soon as the current frame completes. The downstream side has no back-pressure path. If it is not ready when a frame is offered, the frame is discarded and a saturating overflow counter increments.

The controller is one state machine with these states:
- `ST_IDLE`: unconfigured.
- `ST_CFG_LOAD`: launch a configuration word.
- `ST_CFG_SHIFT`: configuration word in flight.
- `ST_ARMED`: configured and waiting.
- `ST_RD_LOAD`: launch a read.
- `ST_RD_SHIFT`: read in flight.
- `ST_RD_DONE`: offer the frame.

Its transitions are:
- `ST_IDLE`→`ST_CFG_LOAD` on `cfg_start`.
- `ST_CFG_LOAD`→`ST_CFG_SHIFT` always.
- `ST_CFG_SHIFT`→`ST_CFG_LOAD` when a word ends and more words remain.
- `ST_CFG_SHIFT`→`ST_ARMED` when the last word ends.
- `ST_ARMED`→`ST_RD_LOAD` when a request is pending.
- `ST_RD_LOAD`→`ST_RD_SHIFT` always.
- `ST_RD_SHIFT`→`ST_RD_DONE` when the frame ends.
- `ST_RD_DONE`→`ST_ARMED` always.

Top module: `eoc_spi_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `out_valid` is 0, `cfg_done` is 0 and `ovf_count` is 0.
- R2: A `cfg_start` pulse in the unconfigured state sends all CFG_COUNT configuration words. Word 0 sits in the least significant 22 bits of CFG_WORDS and goes first. Each word is sent MSB first in its own chip-select frame. After the last word, `cfg_done` goes to 1.
- R3: End-of-conversion edges that occur while `cfg_done` is 0 start no transfer and produce no `out_valid`.
- R4: Once configured, each rising edge of `eoc` starts exactly one 22-bit read, however long `eoc` stays high. During a read, MOSI is held at 0.
- R5: An `eoc` rising edge that arrives during a read is remembered. The next read begins at most 6 system cycles after chip-select rises.
- R6: A completed read is presented on `out_frame` with `out_valid` high for exactly one cycle. The field outputs are decoded as `out_tag`=frame[21:20], `out_ch0`=frame[19:10] and `out_ch1`=frame[9:0].
- R7: When `out_valid` is high while `out_ready` is 0, the frame is lost and `ovf_count` increments by one. The counter stops at its all-ones value.
- R8: The SCLK period equals the divisor in system cycles. The divisor resets to DIV_RESET. `div_load` replaces it while the controller is unconfigured or armed. Bit 0 of the loaded value is cleared, and values below 2 become 2.
- R9: The link uses mode 0. SCLK is low whenever chip-select is high, MOSI is stable while SCLK is high, and every frame contains exactly 22 rising SCLK edges.
- R10: Between two consecutive frames, chip-select stays high for at least two system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Pulse: begin the configuration write sequence |
| div_load | input | 1 | Load `div_value` into the SCLK divisor register |
| div_value | input | DIV_W | New SCLK divisor in system cycles |
| eoc | input | 1 | End-of-conversion from the slave, asynchronous |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip-select, active low |
| spi_mosi | output | 1 | SPI data to the slave |
| spi_miso | input | 1 | SPI data from the slave |
| cfg_done | output | 1 | Configuration finished; reads enabled |
| out_valid | output | 1 | Frame offered downstream (one cycle) |
| out_ready | input | 1 | Downstream can take a frame |
| out_frame | output | 22 | Raw frame read from the slave |
| out_tag | output | 2 | Frame tag field |
| out_ch0 | output | 10 | First channel sample |
| out_ch1 | output | 10 | Second channel sample |
| ovf_count | output | OVF_W | Saturating count of dropped frames |

## Verification
The assertions assume that `spi_miso` changes only on falling SCLK edges or when chip-select falls. They also assume the divisor is never changed while a frame is in flight. The bench meets both conditions with a slave model that updates MISO only at those points, and with a bench that pulses `div_load` only after a read has finished and no `eoc` edge is pending. `eoc` is driven as a clean level that stays high for many system cycles, so the synchronizer sees each edge only once. The one deliberately overlapping request arrives well inside a frame, never in the launch cycle.

// File: rtl/eoc_spi_pkg.sv
package eoc_spi_pkg;

    localparam int FRAME_BITS  = 22;
    localparam int TAG_BITS    = 2;
    localparam int SAMPLE_BITS = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_LOAD,
        ST_CFG_SHIFT,
        ST_ARMED,
        ST_RD_LOAD,
        ST_RD_SHIFT,
        ST_RD_DONE
    } rd_state_e;

endpackage

// File: rtl/eoc_edge_sync.sv
module eoc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_in};
        end
    end

    // Edge is taken between the last synchronizer stage and its history copy
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/sclk_rate_reg.sv
module sclk_rate_reg #(
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               allow,
    input  logic [DIV_W-1:0]   value,
    output logic [DIV_W-2:0]   half
);

    localparam int HALF_W     = DIV_W - 1;
    localparam int HALF_RST_I = (DIV_RESET / 2 < 1) ? 1 : DIV_RESET / 2;
    localparam logic [HALF_W-1:0] HALF_RST = HALF_W'(HALF_RST_I);

    logic [HALF_W-1:0] half_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HALF_RST;
        end else if (load && allow) begin
            if (value[DIV_W-1:1] == '0) begin
                half_q <= HALF_W'(1);
            end else begin
                half_q <= value[DIV_W-1:1];
            end
        end
    end

    assign half = half_q;

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int BITS   = 22,
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS-1:0]   tx_word,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic              busy,
    output logic [BITS-1:0]   rx_word
);

    localparam int BCNT_W = $clog2(BITS);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BITS - 1);

    logic              busy_q;
    logic              sclk_q;
    logic              done_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [BCNT_W-1:0] bitn_q;
    logic [BITS-1:0]   tx_sh_q;
    logic [BITS-1:0]   rx_sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            hcnt_q  <= '0;
            bitn_q  <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    sclk_q  <= 1'b0;
                    hcnt_q  <= '0;
                    bitn_q  <= '0;
                    tx_sh_q <= tx_word;
                end
            end else if (hcnt_q == half - 1'b1) begin
                hcnt_q <= '0;
                if (!sclk_q) begin
                    // Rising edge: capture the slave's bit
                    sclk_q  <= 1'b1;
                    rx_sh_q <= {rx_sh_q[BITS-2:0], miso};
                end else begin
                    // Falling edge: advance or finish
                    sclk_q <= 1'b0;
                    if (bitn_q == LAST_BIT) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bitn_q  <= bitn_q + 1'b1;
                        tx_sh_q <= {tx_sh_q[BITS-2:0], 1'b0};
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_sh_q[BITS-1];
    assign cs_n    = ~busy_q;
    assign done    = done_q;
    assign busy    = busy_q;
    assign rx_word = rx_sh_q;

endmodule

// File: rtl/eoc_spi_reader.sv
module eoc_spi_reader
    import eoc_spi_pkg::*;
#(
    parameter int CFG_COUNT   = 3,
    parameter logic [CFG_COUNT*22-1:0] CFG_WORDS = {22'h0ABCDE, 22'h155AA5, 22'h2C3F01},
    parameter int DIV_W       = 8,
    parameter int DIV_RESET   = 4,
    parameter int OVF_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_start,
    input  logic                   div_load,
    input  logic [DIV_W-1:0]       div_value,
    input  logic                   eoc,
    output logic                   spi_sclk,
    output logic                   spi_cs_n,
    output logic                   spi_mosi,
    input  logic                   spi_miso,
    output logic                   cfg_done,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [FRAME_BITS-1:0]  out_frame,
    output logic [TAG_BITS-1:0]    out_tag,
    output logic [SAMPLE_BITS-1:0] out_ch0,
    output logic [SAMPLE_BITS-1:0] out_ch1,
    output logic [OVF_W-1:0]       ovf_count
);

    localparam int HALF_W = DIV_W - 1;
    localparam int CIDX_W = (CFG_COUNT > 1) ? $clog2(CFG_COUNT) : 1;
    localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CFG_COUNT - 1);
    localparam logic [OVF_W-1:0]  OVF_MAX   = {OVF_W{1'b1}};

    rd_state_e state_q, state_d;

    logic                  eoc_rise;
    logic                  pending_q;
    logic [CIDX_W-1:0]     cfg_idx_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic [OVF_W-1:0]      ovf_q;
    logic [HALF_W-1:0]     half;

    logic                  eng_start;
    logic [FRAME_BITS-1:0] eng_tx;
    logic                  eng_done;
    logic                  eng_busy;
    logic [FRAME_BITS-1:0] eng_rx;

    logic                  armed_any;
    logic                  rate_allow;

    // ---------------- submodules ----------------
    eoc_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (eoc),
        .rise     (eoc_rise)
    );

    sclk_rate_reg #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .allow (rate_allow),
        .value (div_value),
        .half  (half)
    );

    spi_bit_engine #(
        .BITS   (FRAME_BITS),
        .HALF_W (HALF_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_word (eng_tx),
        .half    (half),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .cs_n    (spi_cs_n),
        .done    (eng_done),
        .busy    (eng_busy),
        .rx_word (eng_rx)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cfg_start) state_d = ST_CFG_LOAD;
            ST_CFG_LOAD:  state_d = ST_CFG_SHIFT;
            ST_CFG_SHIFT: if (eng_done) begin
                              state_d = (cfg_idx_q == CIDX_LAST) ? ST_ARMED : ST_CFG_LOAD;
                          end
            ST_ARMED:     if (pending_q) state_d = ST_RD_LOAD;
            ST_RD_LOAD:   state_d = ST_RD_SHIFT;
            ST_RD_SHIFT:  if (eng_done) state_d = ST_RD_DONE;
            ST_RD_DONE:   state_d = ST_ARMED;
            default:      state_d = ST_IDLE;
        endcase
    end

    // ---------------- state outputs ----------------
    always_comb begin
        eng_start  = 1'b0;
        eng_tx     = '0;
        out_valid  = 1'b0;
        armed_any  = 1'b0;
        rate_allow = 1'b0;
        unique case (state_q)
            ST_IDLE:      rate_allow = ~eng_busy;
            ST_CFG_LOAD:  begin
                              eng_start = 1'b1;
                              eng_tx    = CFG_WORDS[cfg_idx_q*FRAME_BITS +: FRAME_BITS];
                          end
            ST_CFG_SHIFT: ;
            ST_ARMED:     begin
                              armed_any  = 1'b1;
                              rate_allow = ~eng_busy;
                          end
            ST_RD_LOAD:   begin
                              armed_any = 1'b1;
                              eng_start = 1'b1;
                          end
            ST_RD_SHIFT:  armed_any = 1'b1;
            ST_RD_DONE:   begin
                              armed_any = 1'b1;
                              out_valid = 1'b1;
                          end
            default:      ;
        endcase
    end

    assign cfg_done = armed_any;

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_idx_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cfg_idx_q <= '0;
        end else if (state_q == ST_CFG_SHIFT && eng_done && cfg_idx_q != CIDX_LAST) begin
            cfg_idx_q <= cfg_idx_q + 1'b1;
        end
    end

    // A new edge wins over the clear so that no request is lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (eoc_rise && armed_any) begin
            pending_q <= 1'b1;
        end else if (state_q == ST_RD_LOAD) begin
            pending_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (state_q == ST_RD_SHIFT && eng_done) begin
            frame_q <= eng_rx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else if (out_valid && !out_ready && ovf_q != OVF_MAX) begin
            ovf_q <= ovf_q + 1'b1;
        end
    end

    assign out_frame = frame_q;
    assign out_tag   = frame_q[FRAME_BITS-1 -: TAG_BITS];
    assign out_ch0   = frame_q[2*SAMPLE_BITS-1 -: SAMPLE_BITS];
    assign out_ch1   = frame_q[SAMPLE_BITS-1:0];
    assign ovf_count = ovf_q;

endmodule

// File: rtl/eoc_spi_reader_chk.sv
module eoc_spi_reader_chk #(
    parameter int OVF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             cfg_done,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OVF_W-1:0] ovf_count
);

    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R9

    AST_MOSI_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R9

    AST_CS_GAP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n); // R10

    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6

    AST_NO_VALID_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !out_valid); // R3

    AST_OVF_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && ovf_count != OVF_MAX) |=> ovf_count == $past(ovf_count) + 1'b1); // R7

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && !out_ready) |=> $stable(ovf_count)); // R7

    AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_count == OVF_MAX |=> ovf_count == OVF_MAX); // R7

endmodule

bind eoc_spi_reader eoc_spi_reader_chk #(
    .OVF_W (OVF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .cfg_done  (cfg_done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .ovf_count (ovf_count)
);

// File: tb/eoc_spi_reader_tb.sv
`timescale 1ns/1ps
module eoc_spi_reader_tb;

    localparam int NCFG = 3;
    localparam logic [21:0] CW0 = 22'h2C3F01;
    localparam logic [21:0] CW1 = 22'h155AA5;
    localparam logic [21:0] CW2 = 22'h0ABCDE;
    localparam int OVF_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic        div_load = 1'b0;
    logic [7:0]  div_value = 8'd0;
    logic        eoc = 1'b0;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        cfg_done, out_valid;
    logic        out_ready = 1'b1;
    logic [21:0] out_frame;
    logic [1:0]  out_tag;
    logic [9:0]  out_ch0, out_ch1;
    logic [OVF_W-1:0] ovf_count;

    always #4 clk = ~clk;

    eoc_spi_reader #(
        .CFG_COUNT   (NCFG),
        .CFG_WORDS   ({CW2, CW1, CW0}),
        .DIV_W       (8),
        .DIV_RESET   (4),
        .OVF_W       (OVF_W),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_start (cfg_start),
        .div_load  (div_load),
        .div_value (div_value),
        .eoc       (eoc),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .cfg_done  (cfg_done),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_frame (out_frame),
        .out_tag   (out_tag),
        .out_ch0   (out_ch0),
        .out_ch1   (out_ch1),
        .ovf_count (ovf_count)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    logic [21:0] miso_q[$];
    logic [21:0] exp_q[$];
    logic [21:0] cfg_exp[NCFG];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // ---------------- slave model ----------------
    logic [21:0] s_sh = '0;
    logic [21:0] s_cap = '0;
    int     s_bits = 0;
    int     frames_seen = 0;
    int     cfg_seen = 0;
    longint t_r1 = 0, t_r2 = 0, t_rise = 0;
    longint last_period = 0, last_gap = 0;
    bit     cs_prev = 1'b1, sclk_prev = 1'b0, mon_on = 1'b0;

    always @(spi_cs_n, spi_sclk) begin
        if (mon_on && cs_prev === 1'b1 && spi_cs_n === 1'b0) begin
            last_gap = ($time - t_rise) / 8;
            s_bits = 0;
            s_cap  = '0;
            if (cfg_done && miso_q.size() > 0) s_sh = miso_q.pop_front();
            else s_sh = '0;
            spi_miso = s_sh[21];
        end else if (mon_on && cs_prev === 1'b0 && spi_cs_n === 1'b1) begin
            t_rise = $time;
            frames_seen++;
            chk(s_bits == 22, "R9 bits/frame", s_bits, 22);
            last_period = (t_r2 - t_r1) / 8;
            if (!cfg_done) begin
                if (cfg_seen < NCFG) chk(s_cap == cfg_exp[cfg_seen], "R2 cfg word", s_cap, cfg_exp[cfg_seen]);
                else chk(1'b0, "R2 extra cfg frame", cfg_seen, NCFG);
                cfg_seen++;
            end else begin
                chk(s_cap == 22'd0, "R4 mosi low in read", s_cap, 0);
            end
        end
        if (mon_on && spi_cs_n === 1'b0 && sclk_prev === 1'b1 && spi_sclk === 1'b0) begin
            s_sh = {s_sh[20:0], 1'b0};
            spi_miso = s_sh[21];
        end
        if (mon_on && spi_cs_n === 1'b0 && sclk_prev === 1'b0 && spi_sclk === 1'b1) begin
            s_cap = {s_cap[20:0], spi_mosi};
            if (s_bits == 0) t_r1 = $time;
            if (s_bits == 1) t_r2 = $time;
            s_bits++;
        end
        cs_prev   = spi_cs_n;
        sclk_prev = spi_sclk;
    end

    // ---------------- scoreboard monitor ----------------
    int delivered = 0;
    int drops_seen = 0;
    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1) begin
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", out_frame, 0);
                end else begin
                    logic [21:0] e;
                    e = exp_q.pop_front();
                    chk(out_frame == e, "R6 frame", out_frame, e);
                    chk(out_tag == e[21:20], "R6 tag", out_tag, e[21:20]);
                    chk(out_ch0 == e[19:10], "R6 ch0", out_ch0, e[19:10]);
                    chk(out_ch1 == e[9:0], "R6 ch1", out_ch1, e[9:0]);
                end
                delivered++;
            end else begin
                drops_seen++;
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pulse_eoc(input int hold);
        @(posedge clk); #1 eoc = 1'b1;
        wait_cycles(hold);
        #1 eoc = 1'b0;
    endtask

    task automatic send_frame(input logic [21:0] f, input bit deliver);
        int target;
        target = frames_seen + 1;
        miso_q.push_back(f);
        if (deliver) exp_q.push_back(f);
        pulse_eoc(40);
        wait (frames_seen == target);
        wait_cycles(10);
    endtask

    task automatic set_div(input logic [7:0] v);
        @(posedge clk); #1 div_value = v; div_load = 1'b1;
        @(posedge clk); #1 div_load = 1'b0;
    endtask

    // ---------------- sequence ----------------
    initial begin
        int base;
        cfg_exp[0] = CW0; cfg_exp[1] = CW1; cfg_exp[2] = CW2;
        wait_cycles(5);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(cfg_done == 1'b0, "R1 cfg_done", cfg_done, 0);
        chk(ovf_count == '0, "R1 ovf", ovf_count, 0);
        mon_on = 1'b1;

        // R3: eoc before configuration
        pulse_eoc(20);
        wait_cycles(300);
        chk(frames_seen == 0, "R3 no transfer unconfigured", frames_seen, 0);
        chk(delivered + drops_seen == 0, "R3 no valid unconfigured", delivered + drops_seen, 0);

        // R2: configuration sequence
        @(posedge clk); #1 cfg_start = 1'b1;
        @(posedge clk); #1 cfg_start = 1'b0;
        wait (cfg_done === 1'b1);
        wait_cycles(5);
        chk(cfg_seen == NCFG, "R2 cfg word count", cfg_seen, NCFG);
        chk(cfg_done == 1'b1, "R2 cfg_done", cfg_done, 1);
        chk(last_period == 4, "R8 reset divisor", last_period, 4);

        // R4: single reads, distinct patterns; one read per edge
        base = frames_seen;
        send_frame(22'h3FFFFF, 1'b1);
        send_frame(22'h000000, 1'b1);
        send_frame({2'b10, 10'h155, 10'h2AA}, 1'b1);
        send_frame({2'b01, 10'h3C1, 10'h00F}, 1'b1);
        wait_cycles(300);
        chk(frames_seen == base + 4, "R4 one read per edge", frames_seen - base, 4);

        // R5: edge during a read
        base = frames_seen;
        miso_q.push_back(22'h123456); exp_q.push_back(22'h123456);
        miso_q.push_back(22'h2DCBA9); exp_q.push_back(22'h2DCBA9);
        pulse_eoc(10);
        wait (spi_cs_n === 1'b0);
        wait_cycles(20);
        pulse_eoc(10);
        wait (frames_seen == base + 2);
        wait_cycles(20);
        chk(last_gap <= 6, "R5 pending read launch", last_gap, 6);
        chk(last_gap >= 2, "R10 cs high gap", last_gap, 2);
        chk(frames_seen == base + 2, "R5 two reads", frames_seen - base, 2);

        // R8: divisor changes
        set_div(8'd8);
        send_frame(22'h0F0F0F, 1'b1);
        chk(last_period == 8, "R8 div 8", last_period, 8);
        set_div(8'd5);
        send_frame(22'h30C30C, 1'b1);
        chk(last_period == 4, "R8 div 5 rounds to 4", last_period, 4);
        set_div(8'd1);
        send_frame(22'h1E1E1E, 1'b1);
        chk(last_period == 2, "R8 div 1 clamps to 2", last_period, 2);
        set_div(8'd0);
        send_frame(22'h2A5A5A, 1'b1);
        chk(last_period == 2, "R8 div 0 clamps to 2", last_period, 2);
        set_div(8'd6);
        send_frame(22'h0000FF, 1'b1);
        chk(last_period == 6, "R8 div 6", last_period, 6);

        // R7: drops and saturation
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) send_frame(22'h100000 + 22'(i), 1'b0);
        chk(ovf_count == 4'd3, "R7 ovf count 3", ovf_count, 3);
        out_ready = 1'b1;
        send_frame(22'h3ABCDE, 1'b1);
        chk(ovf_count == 4'd3, "R7 ovf unchanged when ready", ovf_count, 3);
        out_ready = 1'b0;
        for (int i = 0; i < 14; i++) send_frame(22'h200000 + 22'(i), 1'b0);
        chk(ovf_count == 4'hF, "R7 ovf saturates", ovf_count, 15);
        chk(drops_seen == 17, "R7 drops observed", drops_seen, 17);
        out_ready = 1'b1;
        send_frame(22'h155555, 1'b1);
        chk(ovf_count == 4'hF, "R7 ovf held at max", ovf_count, 15);

        wait_cycles(50);
        chk(exp_q.size() == 0, "R6 all frames delivered", exp_q.size(), 0);
        chk(delivered == 13, "R6 delivered count", delivered, 13);
        finish_run();
    end

endmodule